// File: doc/BRIEF.md
# Multi-CPU level interrupt aggregator

This block is a first-level interrupt controller. It collects a parameterised number of level-sensitive peripheral request lines, grouped in 32-bit words, and drives one registered request line into each CPU. Each CPU has a complete register bank of its own: a status view, a read-only mask, and two write-only ports. Writing ones to the set port masks sources, and writing ones to the clear port unmasks them. Because the masks are separate, any source can be steered to any subset of CPUs.

Requests pass straight through, with no polarity, edge or priority processing. No vector is produced. To find the pending sources, software reads every status word of its bank. Each status bit is the raw input AND NOT that CPU's mask bit. A CPU's output is the registered OR of all the status bits in its bank.

Register access uses a simple memory-mapped bus. A read is accepted in one cycle and answered on the next. A two-state sequencer runs the reads. In state BUS_IDLE, no response is driven. The transition BUS_IDLE to BUS_RESP is taken when a read is accepted. In state BUS_RESP, `rd_valid` is high. The transition BUS_RESP to BUS_RESP is taken on a back-to-back read. The transition BUS_RESP to BUS_IDLE is taken when no read is accepted. Writes never leave BUS_IDLE.

Top module: `irq_agg_top`

## Requirements
- R1: Word-aligned byte addresses decode as `cpu * 2**BANK_LOG2 + grp * WORDS * 4 + word * 4`, where `WORDS = NUM_IRQ / 32` and NUM_IRQ is 64, 96, 128 or 160. The group codes are status = 0, set = 1, clear = 2, mask = 3, and bit b of word w stands for input `32*w + b`.
- R2: After reset, every mask bit in every bank is 1 and every `cpu_irq` bit is 0.
- R3: A status word reads as `irq_in & ~mask` for that CPU and word, sampled in the cycle the read is accepted.
- R4: Writing to the set port sets exactly the mask bits written as 1, from the next cycle on. All other mask bits keep their values.
- R5: Writing to the clear port clears exactly the mask bits written as 1, from the next cycle on. All other mask bits keep their values.
- R6: The set and clear ports read as zero.
- R7: Writes to the status or mask group have no effect on any mask.
- R8: An access to one CPU's bank never changes another CPU's mask.
- R9: `cpu_irq[c]` equals the OR of all of CPU c's status bits as they stood one clock edge earlier.
- R10: A misaligned address, an offset beyond the four groups, or a CPU index of NUM_CPU or more reads as zero, and a write to such an address is ignored.
- R11: A read accepted in one cycle raises `rd_valid` for exactly the next cycle. Writes produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Level-sensitive source requests |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read) |
| rd_data | output | 32 | Read data |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The stimulus mixes random 96-bit input patterns with random set and clear writes across CPUs and words. The bench compares every status read, every mask read and every `cpu_irq` bit against a bench-side mask model. All-ones inputs under the reset mask show that masking works: status must stay zero however busy the inputs are. Single-bit and alternating-bit set and clear patterns catch a port that disturbs bits it was not given. Writing to one CPU and then reading the other catches banks that share state. Probes of the decode boundaries cover the last word of the mask group, the first offset past it, and a misaligned address, and separate a correct decode from an off-by-one error. A probe of the output in the cycle of an input change, taken again one edge later, confirms the one-cycle latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register group codes within a CPU bank (order fixes the address map)
    typedef enum logic [1:0] {
        GRP_STATUS = 2'd0,
        GRP_SET    = 2'd1,
        GRP_CLEAR  = 2'd2,
        GRP_MASK   = 2'd3
    } grp_e;

    // Read response sequencer states
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int WORD_BITS = 32;
    localparam int NUM_GROUPS = 4;

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_CPU   = 2,
    parameter int WORDS     = 3,
    parameter int ADDR_W    = 8,
    parameter int BANK_LOG2 = 7,
    parameter int CPU_W     = ADDR_W - BANK_LOG2,
    parameter int WIDX_W    = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CPU_W-1:0]  cpu,
    output grp_e              grp,
    output logic [WIDX_W-1:0] word
);

    localparam int OFF_W = BANK_LOG2 - 2;

    logic [OFF_W-1:0] woff;
    logic             aligned;
    int               wi;
    int               gi;

    always_comb begin
        woff    = addr[BANK_LOG2-1:2];
        aligned = (addr[1:0] == 2'b00);
        cpu     = addr[ADDR_W-1:BANK_LOG2];
        wi      = int'(woff);
        gi      = wi / WORDS;
        grp     = grp_e'(2'(gi));
        word    = WIDX_W'(wi % WORDS);
        hit     = aligned
                  && (int'(cpu) < NUM_CPU)
                  && (wi < NUM_GROUPS * WORDS);
    end

endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
    import irq_agg_pkg::*;
#(
    parameter int WORDS = 3,
    parameter int NBITS = WORDS * WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] irq_in,
    input  logic [NBITS-1:0] set_vec,
    input  logic [NBITS-1:0] clr_vec,
    output logic [NBITS-1:0] mask_o,
    output logic [NBITS-1:0] status_o,
    output logic             irq_o
);

    logic [WORD_BITS-1:0] mask_w [WORDS];
    logic                 irq_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_BITS-1:0] set_w;
        logic [WORD_BITS-1:0] clr_w;

        assign set_w = set_vec[w*WORD_BITS +: WORD_BITS];
        assign clr_w = clr_vec[w*WORD_BITS +: WORD_BITS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_w[w] <= '1;
            end else begin
                mask_w[w] <= (mask_w[w] | set_w) & ~clr_w;
            end
        end

        assign mask_o[w*WORD_BITS +: WORD_BITS]   = mask_w[w];
        assign status_o[w*WORD_BITS +: WORD_BITS] = irq_in[w*WORD_BITS +: WORD_BITS] & ~mask_w[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |status_o;
        end
    end

    assign irq_o = irq_q;

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask_o)); // R2

    AST_SET_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) && (clr_vec == '0) |=>
            ((mask_o & $past(set_vec)) == $past(set_vec))
            && ((mask_o & ~$past(set_vec)) == ($past(mask_o) & ~$past(set_vec)))); // R4

    AST_CLR_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) && (set_vec == '0) |=>
            ((mask_o & $past(clr_vec)) == '0)
            && ((mask_o & ~$past(clr_vec)) == ($past(mask_o) & ~$past(clr_vec)))); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) && (clr_vec == '0) |=> $stable(mask_o)); // R7

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> (irq_o == $past(|status_o))); // R9

endmodule

// File: rtl/irq_agg_bus_fsm.sv
module irq_agg_bus_fsm
    import irq_agg_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int WORDS   = 3,
    parameter int NBITS   = WORDS * WORD_BITS,
    parameter int CPU_W   = 1,
    parameter int WIDX_W  = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_req,
    input  logic                        hit,
    input  logic [CPU_W-1:0]            cpu,
    input  grp_e                        grp,
    input  logic [WIDX_W-1:0]           word,
    input  logic [NUM_CPU-1:0][NBITS-1:0] status_all,
    input  logic [NUM_CPU-1:0][NBITS-1:0] mask_all,
    output logic                        rd_valid,
    output logic [WORD_BITS-1:0]        rd_data
);

    bus_state_e           state_q;
    bus_state_e           state_d;
    logic [WORD_BITS-1:0] sel_word;
    logic [WORD_BITS-1:0] data_q;
    logic [NBITS-1:0]     sel_status;
    logic [NBITS-1:0]     sel_mask;

    // Pick the addressed CPU's vectors (loop avoids a variable index)
    always_comb begin
        sel_status = '0;
        sel_mask   = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu == CPU_W'(c)) begin
                sel_status = status_all[c];
                sel_mask   = mask_all[c];
            end
        end
    end

    // Word and group selection
    always_comb begin
        sel_word = '0;
        if (hit) begin
            for (int w = 0; w < WORDS; w++) begin
                if (word == WIDX_W'(w)) begin
                    unique case (grp)
                        GRP_STATUS: sel_word = sel_status[w*WORD_BITS +: WORD_BITS];
                        GRP_MASK:   sel_word = sel_mask[w*WORD_BITS +: WORD_BITS];
                        GRP_SET,
                        GRP_CLEAR:  sel_word = '0;
                    endcase
                end
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_req) begin
            data_q <= sel_word;
        end
    end

    // Outputs from state
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            BUS_RESP: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
        endcase
    end

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R11

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid); // R11

    AST_PORTS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && hit && ((grp == GRP_SET) || (grp == GRP_CLEAR)) |=> (rd_data == '0)); // R6

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !hit |=> (rd_data == '0)); // R10

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_IRQ   = 96,
    parameter int NUM_CPU   = 2,
    parameter int BANK_LOG2 = 7,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [NUM_CPU-1:0]   cpu_irq
);

    localparam int WORDS  = NUM_IRQ / WORD_BITS;
    localparam int NBITS  = WORDS * WORD_BITS;
    localparam int CPU_W  = ADDR_W - BANK_LOG2;
    localparam int WIDX_W = $clog2(WORDS);

    logic                          hit;
    logic [CPU_W-1:0]              dec_cpu;
    grp_e                          dec_grp;
    logic [WIDX_W-1:0]             dec_word;
    logic                          wr_req;
    logic                          rd_req;
    logic [NBITS-1:0]              wdata_pos;
    logic [NUM_CPU-1:0][NBITS-1:0] status_all;
    logic [NUM_CPU-1:0][NBITS-1:0] mask_all;

    assign wr_req    = bus_valid && bus_write && hit;
    assign rd_req    = bus_valid && !bus_write;
    assign wdata_pos = NBITS'(bus_wdata) << (WORD_BITS * int'(dec_word));

    irq_agg_decode #(
        .NUM_CPU   (NUM_CPU),
        .WORDS     (WORDS),
        .ADDR_W    (ADDR_W),
        .BANK_LOG2 (BANK_LOG2),
        .CPU_W     (CPU_W),
        .WIDX_W    (WIDX_W)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .cpu  (dec_cpu),
        .grp  (dec_grp),
        .word (dec_word)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic             sel;
        logic [NBITS-1:0] set_vec;
        logic [NBITS-1:0] clr_vec;

        assign sel     = wr_req && (dec_cpu == CPU_W'(c));
        assign set_vec = (sel && dec_grp == GRP_SET)   ? wdata_pos : '0;
        assign clr_vec = (sel && dec_grp == GRP_CLEAR) ? wdata_pos : '0;

        irq_agg_bank #(
            .WORDS (WORDS),
            .NBITS (NBITS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[NBITS-1:0]),
            .set_vec  (set_vec),
            .clr_vec  (clr_vec),
            .mask_o   (mask_all[c]),
            .status_o (status_all[c]),
            .irq_o    (cpu_irq[c])
        );
    end

    irq_agg_bus_fsm #(
        .NUM_CPU (NUM_CPU),
        .WORDS   (WORDS),
        .NBITS   (NBITS),
        .CPU_W   (CPU_W),
        .WIDX_W  (WIDX_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .hit        (hit),
        .cpu        (dec_cpu),
        .grp        (dec_grp),
        .word       (dec_word),
        .status_all (status_all),
        .mask_all   (mask_all),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    AST_OUT_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_irq == '0)); // R2

    AST_WRITE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> !rd_valid); // R11

endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;

    localparam int NUM_IRQ = 96;
    localparam int NUM_CPU = 2;
    localparam int WORDS   = NUM_IRQ / 32;
    localparam int ADDR_W  = 8;
    localparam int BANK    = 128;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_IRQ-1:0] irq_in = '0;
    logic               bus_valid = 1'b0;
    logic               bus_write = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [NUM_CPU-1:0] cpu_irq;

    logic [NUM_IRQ-1:0] mdl_mask [NUM_CPU];
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    irq_agg_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .cpu_irq(cpu_irq)
    );

    function automatic logic [ADDR_W-1:0] reg_addr(int cpu, int grp, int word);
        return ADDR_W'(cpu * BANK + grp * WORDS * 4 + word * 4);
    endfunction

    function automatic logic [31:0] exp_status(int cpu, int word);
        logic [NUM_IRQ-1:0] s;
        s = irq_in & ~mdl_mask[cpu];
        return s[word*32 +: 32];
    endfunction

    function automatic logic [31:0] exp_mask(int cpu, int word);
        logic [NUM_IRQ-1:0] m;
        m = mdl_mask[cpu];
        return m[word*32 +: 32];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R11 no response to write", 32'(rd_valid), 32'd0);
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R11 rd_valid after read", 32'(rd_valid), 32'd1);
        d = rd_data;
    endtask

    task automatic model_set(int cpu, int word, logic [31:0] d);
        logic [NUM_IRQ-1:0] v;
        v = NUM_IRQ'(d) << (32 * word);
        mdl_mask[cpu] = mdl_mask[cpu] | v;
    endtask

    task automatic model_clr(int cpu, int word, logic [31:0] d);
        logic [NUM_IRQ-1:0] v;
        v = NUM_IRQ'(d) << (32 * word);
        mdl_mask[cpu] = mdl_mask[cpu] & ~v;
    endtask

    // one edge with stable mask and inputs, then compare outputs (R9)
    task automatic check_outputs(string tag);
        @(negedge clk);
        for (int c = 0; c < NUM_CPU; c++) begin
            check(tag, 32'(cpu_irq[c]), 32'(|(irq_in & ~mdl_mask[c])));
        end
    endtask

    task automatic check_all_regs(string tag_s, string tag_m);
        logic [31:0] d;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int w = 0; w < WORDS; w++) begin
                do_read(reg_addr(c, 0, w), d);
                check(tag_s, d, exp_status(c, w));
                do_read(reg_addr(c, 3, w), d);
                check(tag_m, d, exp_mask(c, w));
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NUM_CPU; c++) mdl_mask[c] = '1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_in = '1;

        // R2 reset state: all masked, outputs low
        check_outputs("R2 cpu_irq after reset");
        check_all_regs("R3 status zero under reset mask", "R2 mask reset ones");

        // R9 latency: unmask bit 5 of cpu0 with input high
        do_write(reg_addr(0, 2, 0), 32'h0000_0020);
        model_clr(0, 0, 32'h0000_0020);
        check("R9 output not yet changed", 32'(cpu_irq[0]), 32'd0);
        check_outputs("R9 output one edge after mask change");
        @(negedge clk);
        irq_in = '0;
        check("R9 output holds before edge", 32'(cpu_irq[0]), 32'd1);
        check_outputs("R9 output falls one edge after input");

        // R4/R5 atomic patterns on cpu1 word 2
        do_write(reg_addr(1, 2, 2), 32'hAAAA_AAAA);
        model_clr(1, 2, 32'hAAAA_AAAA);
        do_read(reg_addr(1, 3, 2), d);
        check("R5 clear only ones", d, 32'h5555_5555);
        do_write(reg_addr(1, 1, 2), 32'h0000_0002);
        model_set(1, 2, 32'h0000_0002);
        do_read(reg_addr(1, 3, 2), d);
        check("R4 set only ones", d, 32'h5555_5557);
        do_read(reg_addr(0, 3, 2), d);
        check("R8 cpu0 mask untouched", d, 32'hFFFF_FFFF);

        // R6 ports read zero
        do_read(reg_addr(1, 1, 2), d);
        check("R6 set port reads zero", d, 32'd0);
        do_read(reg_addr(0, 2, 1), d);
        check("R6 clear port reads zero", d, 32'd0);

        // R7 writes to status and mask groups ignored
        do_write(reg_addr(1, 3, 2), 32'h0000_0000);
        do_write(reg_addr(1, 0, 2), 32'hFFFF_FFFF);
        do_read(reg_addr(1, 3, 2), d);
        check("R7 mask write ignored", d, 32'h5555_5557);

        // R10 decode boundaries
        irq_in = '1;
        do_read(reg_addr(1, 3, WORDS - 1), d);
        check("R1 last mask word", d, exp_mask(1, WORDS - 1));
        do_read(reg_addr(1, 4, 0), d);
        check("R10 offset past groups", d, 32'd0);
        do_read(reg_addr(0, 0, 0) + ADDR_W'(1), d);
        check("R10 misaligned read", d, 32'd0);
        do_write(reg_addr(0, 2, 0) + ADDR_W'(2), 32'hFFFF_FFFF);
        do_write(reg_addr(0, 4, 1), 32'hFFFF_FFFF);
        do_read(reg_addr(0, 3, 0), d);
        check("R10 stray writes ignored", d, exp_mask(0, 0));
        @(negedge clk);
        check("R11 rd_valid single cycle", 32'(rd_valid), 32'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op, c, w;
            logic [31:0] v;
            irq_in = {$urandom, $urandom, $urandom};
            op = int'($urandom % 4);
            c  = int'($urandom % NUM_CPU);
            w  = int'($urandom % WORDS);
            v  = $urandom & $urandom;
            unique case (op)
                0: begin do_write(reg_addr(c, 1, w), v); model_set(c, w, v); end
                1: begin do_write(reg_addr(c, 2, w), v); model_clr(c, w, v); end
                2: begin do_read(reg_addr(c, 0, w), d); check("R3 random status", d, exp_status(c, w)); end
                default: begin do_read(reg_addr(c, 3, w), d); check("R4 R5 random mask", d, exp_mask(c, w)); end
            endcase
            check_outputs("R9 random output");
        end
        check_all_regs("R3 final status", "R8 final masks");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule